// File: doc/BRIEF.md
# Interrupt Source Delivery Controller

This block keeps the state of a bank of interrupt sources and offers their interrupts, one at a time, to a single presentation controller. Every source has a configurable priority and target server, and remembers whether an offer to it failed (a resend mark) and whether it fired while masked (a held arrival). The all-ones priority masks a source. An offer for a masked source does not reach the presenter. Instead, the held arrival is recorded, whether the offer came from a fresh arrival or from a resend.

Offers use a valid/ready handshake. Each offer carries the interrupt number, the priority and the server. A result phase then returns accept or fail, a displaced interrupt number and the presenter's need-resend flag. A displaced interrupt from this bank is offered again at once. A failed offer marks the source for resend and pulses a mark toward the presenter. If the presenter's need-resend flag is already clear, the failed offer is retried immediately. A scan request walks the whole bank and re-offers every marked source. Level sources whose line is still high at end-of-interrupt are offered again.

Top module: `isd_ctrl`

## Requirements
- R1: After reset, no offer and no mark is driven, `busy_o` is low, every source priority is 0xFF (masked) and every server is 0.
- R2: Source i is offered as interrupt number IRQ_BASE+i (IRQ_BASE=16 by default), with its configured priority and server. Number, priority and server stay stable while the offer waits for ready.
- R3: An arrival on a source whose priority is 0xFF produces no offer and sets that source's held-arrival flag.
- R4: Writing a priority other than 0xFF to a source whose held-arrival flag is set clears the flag and offers the source with the newly written priority and server.
- R5: When an offer is accepted with a displaced number that is inside the bank, is not 0 and is not the IPI code (2), that source is offered next. Any other displaced value causes no further offer.
- R6: A failed result sets the source's resend mark and pulses `mark_o` for one cycle. If `res_need_resend_i` is low, the same source is offered again at once. If it is high, nothing more happens until a scan.
- R7: A scan re-offers exactly the sources holding a resend mark, in ascending index order. Every offer attempt clears the mark first, so a second scan after successful offers produces no offer.
- R8: An end-of-interrupt for a bank source whose level input is high causes a new offer. If the level input is low, it causes none.
- R9: A redeliver request with an in-bank number (not 0, not 2) causes an offer of that source.
- R10: Pending arrivals are served lowest index first. A pending scan request is served before pending arrivals. `busy_o` stays high from the start of an attempt or scan until it and all chained retries end.
- R11: A marked source that has been masked is not offered by a scan. Its mark is cleared and its held-arrival flag is set, so a later unmask (R4) still offers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arrive_i | input | N_SRC | Per-source arrival pulse |
| level_i | input | N_SRC | Per-source level line (0 for message sources) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index to configure |
| cfg_prio_i | input | PRIO_W | Priority to write (all ones = masked) |
| cfg_srv_i | input | SRV_W | Target server to write |
| redo_valid_i | input | 1 | Redeliver request strobe |
| redo_irq_i | input | IRQ_W | Interrupt number to redeliver |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_irq_i | input | IRQ_W | Interrupt number being ended |
| scan_i | input | 1 | Resend scan request |
| offer_valid_o | output | 1 | Offer valid |
| offer_ready_i | input | 1 | Presenter takes the offer |
| offer_irq_o | output | IRQ_W | Offered interrupt number |
| offer_prio_o | output | PRIO_W | Offered priority |
| offer_srv_o | output | SRV_W | Offered target server |
| res_valid_i | input | 1 | Result of the last offer is valid |
| res_accept_i | input | 1 | Offer accepted (1) or failed (0) |
| res_displaced_i | input | IRQ_W | Interrupt number displaced by an accept |
| res_need_resend_i | input | 1 | Presenter's need-resend flag at result time |
| mark_o | output | 1 | Pulse: set the presenter-side resend bit for this bank |
| busy_o | output | 1 | An attempt, chain or scan is in progress |

## Verification
The main collision is a scan request and a fresh arrival in the same cycle, while other sources still hold resend marks. The bench pulses `scan_i` and `arrive_i` on the same edge. It expects the marked sources to be offered in index order, followed by the fresh arrival. Any other order, or a lost arrival, shows up as a mismatch in the scoreboard. A second overlap is a masking write that lands while a source is marked. That write must turn the next scan visit into a held arrival and not into an offer.

// File: rtl/isd_pkg.sv
package isd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_WAIT  = 2'd2,
        ST_SCAN  = 2'd3
    } isd_state_e;
endpackage

// File: rtl/isd_irq_decode.sv
module isd_irq_decode #(
    parameter int unsigned IRQ_W    = 8,
    parameter int unsigned N_SRC    = 16,
    parameter int unsigned IRQ_BASE = 16,
    parameter int unsigned IPI_CODE = 2,
    parameter int unsigned IDX_W    = 4
) (
    input  logic [IRQ_W-1:0] irq_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [31:0] wide;
    logic [31:0] off;

    assign wide  = 32'(irq_i);
    assign off   = wide - IRQ_BASE;
    assign hit_o = (wide != 32'd0) && (wide != IPI_CODE) &&
                   (wide >= IRQ_BASE) && (wide < IRQ_BASE + N_SRC);
    assign idx_o = off[IDX_W-1:0];
endmodule

// File: rtl/isd_lowest.sv
module isd_lowest #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/isd_ctrl.sv
module isd_ctrl
    import isd_pkg::*;
#(
    parameter int unsigned N_SRC    = 16,
    parameter int unsigned IRQ_W    = 8,
    parameter int unsigned IRQ_BASE = 16,
    parameter int unsigned IPI_CODE = 2,
    parameter int unsigned PRIO_W   = 8,
    parameter int unsigned SRV_W    = 4,
    localparam int unsigned IDX_W   = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  arrive_i,
    input  logic [N_SRC-1:0]  level_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic [SRV_W-1:0]  cfg_srv_i,
    input  logic              redo_valid_i,
    input  logic [IRQ_W-1:0]  redo_irq_i,
    input  logic              eoi_valid_i,
    input  logic [IRQ_W-1:0]  eoi_irq_i,
    input  logic              scan_i,
    output logic              offer_valid_o,
    input  logic              offer_ready_i,
    output logic [IRQ_W-1:0]  offer_irq_o,
    output logic [PRIO_W-1:0] offer_prio_o,
    output logic [SRV_W-1:0]  offer_srv_o,
    input  logic              res_valid_i,
    input  logic              res_accept_i,
    input  logic [IRQ_W-1:0]  res_displaced_i,
    input  logic              res_need_resend_i,
    output logic              mark_o,
    output logic              busy_o
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};
    localparam logic [IDX_W-1:0]  LAST   = IDX_W'(N_SRC - 1);

    typedef struct packed {
        isd_state_e                     st;
        logic                           scanning;
        logic                           scan_pend;
        logic [IDX_W-1:0]               cur;
        logic [IDX_W-1:0]               ptr;
        logic [PRIO_W-1:0]              cur_prio;
        logic [SRV_W-1:0]               cur_srv;
        logic [N_SRC-1:0]               req;
        logic [N_SRC-1:0]               resend;
        logic [N_SRC-1:0]               held;
        logic [N_SRC-1:0][PRIO_W-1:0]   prio;
        logic [N_SRC-1:0][SRV_W-1:0]    srv;
    } regs_t;

    regs_t q, d;

    logic             disp_hit, redo_hit, eoi_hit, req_any;
    logic [IDX_W-1:0] disp_idx, redo_idx, eoi_idx, req_idx;

    isd_irq_decode #(.IRQ_W(IRQ_W), .N_SRC(N_SRC), .IRQ_BASE(IRQ_BASE),
                     .IPI_CODE(IPI_CODE), .IDX_W(IDX_W))
        u_dec_disp (.irq_i(res_displaced_i), .hit_o(disp_hit), .idx_o(disp_idx));
    isd_irq_decode #(.IRQ_W(IRQ_W), .N_SRC(N_SRC), .IRQ_BASE(IRQ_BASE),
                     .IPI_CODE(IPI_CODE), .IDX_W(IDX_W))
        u_dec_redo (.irq_i(redo_irq_i), .hit_o(redo_hit), .idx_o(redo_idx));
    isd_irq_decode #(.IRQ_W(IRQ_W), .N_SRC(N_SRC), .IRQ_BASE(IRQ_BASE),
                     .IPI_CODE(IPI_CODE), .IDX_W(IDX_W))
        u_dec_eoi (.irq_i(eoi_irq_i), .hit_o(eoi_hit), .idx_o(eoi_idx));

    isd_lowest #(.N(N_SRC), .IDX_W(IDX_W))
        u_pick (.vec_i(q.req), .any_o(req_any), .idx_o(req_idx));

    logic             start_en, fin;
    logic [IDX_W-1:0] start_idx;

    always_comb begin
        d         = q;
        start_en  = 1'b0;
        start_idx = q.cur;
        fin       = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (q.scan_pend) begin
                    d.scan_pend = 1'b0;
                    d.scanning  = 1'b1;
                    d.ptr       = '0;
                    d.st        = ST_SCAN;
                end else if (req_any) begin
                    d.req[req_idx] = 1'b0;
                    start_en       = 1'b1;
                    start_idx      = req_idx;
                end
            end
            ST_SCAN: begin
                if (q.resend[q.ptr]) begin
                    start_en  = 1'b1;
                    start_idx = q.ptr;
                end else begin
                    fin = 1'b1;
                end
            end
            ST_OFFER: begin
                if (offer_ready_i) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (res_valid_i) begin
                    if (res_accept_i) begin
                        if (disp_hit) begin
                            start_en  = 1'b1;
                            start_idx = disp_idx;
                        end else begin
                            fin = 1'b1;
                        end
                    end else begin
                        d.resend[q.cur] = 1'b1;
                        if (!res_need_resend_i) begin
                            start_en  = 1'b1;
                            start_idx = q.cur;
                        end else begin
                            fin = 1'b1;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // every attempt drops the resend mark before anything else
        if (start_en) begin
            d.resend[start_idx] = 1'b0;
            if (q.prio[start_idx] == MASKED) begin
                d.held[start_idx] = 1'b1;
                fin = 1'b1;
            end else begin
                d.st       = ST_OFFER;
                d.cur      = start_idx;
                d.cur_prio = q.prio[start_idx];
                d.cur_srv  = q.srv[start_idx];
            end
        end

        if (fin) begin
            if (q.scanning) begin
                if (q.ptr == LAST) begin
                    d.scanning = 1'b0;
                    d.st       = ST_IDLE;
                end else begin
                    d.ptr = q.ptr + 1'b1;
                    d.st  = ST_SCAN;
                end
            end else begin
                d.st = ST_IDLE;
            end
        end

        if (cfg_we_i) begin
            d.prio[cfg_idx_i] = cfg_prio_i;
            d.srv[cfg_idx_i]  = cfg_srv_i;
            if (cfg_prio_i != MASKED && d.held[cfg_idx_i]) begin
                d.held[cfg_idx_i] = 1'b0;
                d.req[cfg_idx_i]  = 1'b1;
            end
        end

        d.req = d.req | arrive_i;
        if (redo_valid_i && redo_hit) d.req[redo_idx] = 1'b1;
        if (eoi_valid_i && eoi_hit && level_i[eoi_idx]) d.req[eoi_idx] = 1'b1;
        if (scan_i) d.scan_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prio <= '1;
        end else begin
            q <= d;
        end
    end

    assign offer_valid_o = (q.st == ST_OFFER);
    assign offer_irq_o   = IRQ_W'(IRQ_BASE) + IRQ_W'(q.cur);
    assign offer_prio_o  = q.cur_prio;
    assign offer_srv_o   = q.cur_srv;
    assign mark_o        = (q.st == ST_WAIT) && res_valid_i && !res_accept_i;
    assign busy_o        = (q.st != ST_IDLE);
endmodule

// File: rtl/isd_ctrl_chk.sv
module isd_ctrl_chk #(
    parameter int unsigned N_SRC    = 16,
    parameter int unsigned IRQ_W    = 8,
    parameter int unsigned IRQ_BASE = 16,
    parameter int unsigned PRIO_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              offer_valid_o,
    input logic              offer_ready_i,
    input logic [IRQ_W-1:0]  offer_irq_o,
    input logic [PRIO_W-1:0] offer_prio_o,
    input logic              mark_o,
    input logic              busy_o
);
    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid_o && !offer_ready_i |=>
            offer_valid_o && $stable(offer_irq_o) && $stable(offer_prio_o)); // R2

    AST_OFFER_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid_o |-> (32'(offer_irq_o) >= IRQ_BASE) &&
                          (32'(offer_irq_o) < IRQ_BASE + N_SRC)); // R2

    AST_OFFER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid_o |-> offer_prio_o != {PRIO_W{1'b1}}); // R3

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !offer_valid_o && !mark_o); // R10

    AST_ONE_OFFER_PER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid_o && offer_ready_i |=> !offer_valid_o); // R6
endmodule

bind isd_ctrl isd_ctrl_chk #(
    .N_SRC(N_SRC), .IRQ_W(IRQ_W), .IRQ_BASE(IRQ_BASE), .PRIO_W(PRIO_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .offer_valid_o(offer_valid_o),
    .offer_ready_i(offer_ready_i), .offer_irq_o(offer_irq_o),
    .offer_prio_o(offer_prio_o), .mark_o(mark_o), .busy_o(busy_o)
);

// File: tb/isd_ctrl_tb_top.sv
`timescale 1ns/1ps
module isd_ctrl_tb_top;
    localparam int N = 16;
    localparam int IW = 8;
    localparam int PW = 8;
    localparam int SW = 4;
    localparam int XW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]  arrive = '0, level = '0;
    logic          cfg_we = 0, redo_v = 0, eoi_v = 0, scan = 0;
    logic [XW-1:0] cfg_idx = '0;
    logic [PW-1:0] cfg_prio = '0;
    logic [SW-1:0] cfg_srv = '0;
    logic [IW-1:0] redo_irq = '0, eoi_irq = '0, res_disp = '0;
    logic          res_v = 0, res_acc = 0, res_nr = 0;
    logic          offer_valid, mark, busy;
    logic [IW-1:0] offer_irq;
    logic [PW-1:0] offer_prio;
    logic [SW-1:0] offer_srv;

    isd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .arrive_i(arrive), .level_i(level),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_prio_i(cfg_prio), .cfg_srv_i(cfg_srv),
        .redo_valid_i(redo_v), .redo_irq_i(redo_irq), .eoi_valid_i(eoi_v), .eoi_irq_i(eoi_irq),
        .scan_i(scan), .offer_valid_o(offer_valid), .offer_ready_i(1'b1),
        .offer_irq_o(offer_irq), .offer_prio_o(offer_prio), .offer_srv_o(offer_srv),
        .res_valid_i(res_v), .res_accept_i(res_acc), .res_displaced_i(res_disp),
        .res_need_resend_i(res_nr), .mark_o(mark), .busy_o(busy)
    );

    typedef struct {
        int irq; int prio; int srv; bit acc; int disp; bit nr; string req;
    } exp_t;
    exp_t exp_q[$];

    int vectors = 0, miscompares = 0, marks = 0, exp_marks = 0;
    bit due = 0, done = 0;
    exp_t cur;

    task automatic chk(string req, int act, int expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic push(int irq, int prio, int srv, bit acc, int disp, bit nr, string req);
        exp_t e;
        e.irq = irq; e.prio = prio; e.srv = srv; e.acc = acc; e.disp = disp; e.nr = nr; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor + presenter model: scoreboard pops one item per offer
    always @(negedge clk) begin : mon
        bit saw;
        if (rst_n && !done) begin
            saw = offer_valid;
            if (due) begin
                res_v = 1; res_acc = cur.acc; res_disp = IW'(cur.disp); res_nr = cur.nr; due = 0;
            end else begin
                res_v = 0; res_acc = 0; res_disp = '0; res_nr = 0;
            end
            if (saw) begin
                if (exp_q.size() == 0) begin
                    miscompares++; vectors++;
                    $display("FAIL R2: actual offer %0d expected none", offer_irq);
                    cur.acc = 1; cur.disp = 0; cur.nr = 0;
                end else begin
                    cur = exp_q.pop_front();
                    chk({cur.req, " irq"}, int'(offer_irq), cur.irq);
                    chk({cur.req, " prio"}, int'(offer_prio), cur.prio);
                    chk({cur.req, " srv"}, int'(offer_srv), cur.srv);
                end
                due = 1;
            end
            #1;
            if (mark) marks++;
        end
    end

    task automatic cfg(int idx, int prio, int srv);
        @(negedge clk);
        cfg_we = 1; cfg_idx = XW'(idx); cfg_prio = PW'(prio); cfg_srv = SW'(srv);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic fire(logic [N-1:0] m, bit sc);
        @(negedge clk);
        arrive = m; scan = sc;
        @(negedge clk);
        arrive = '0; scan = 0;
    endtask

    task automatic settle(string req);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 200 && (busy || due || res_v); i++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk({req, " pending offers"}, exp_q.size(), 0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 offer_valid", offer_valid, 0);
        chk("R1 busy", busy, 0);
        chk("R1 mark", mark, 0);

        // R1/R3: reset priority masks; arrival is held, no offer
        fire(16'h0008, 0);
        settle("R3");
        // R4: unmask with held arrival -> offer with new prio, server 0 kept
        push(19, 5, 0, 1, 0, 0, "R4");
        cfg(3, 5, 0);
        settle("R4");

        // R2: plain offer
        cfg(0, 4, 2);
        push(16, 4, 2, 1, 0, 0, "R2");
        fire(16'h0001, 0);
        settle("R2");

        // R10: lowest index first
        cfg(5, 9, 1); cfg(2, 7, 3);
        push(18, 7, 3, 1, 0, 0, "R10"); push(21, 9, 1, 1, 0, 0, "R10");
        fire(16'h0024, 0);
        settle("R10");

        // R5: displaced chain, then IPI code and out-of-bank end it
        cfg(1, 3, 1); cfg(6, 10, 2);
        push(17, 3, 1, 1, 22, 0, "R5"); push(22, 10, 2, 1, 2, 0, "R5");
        fire(16'h0002, 0);
        settle("R5");
        push(17, 3, 1, 1, 200, 0, "R5");
        fire(16'h0002, 0);
        settle("R5");

        // R6: fail with need-resend clear -> immediate retry
        cfg(11, 1, 5);
        push(27, 1, 5, 0, 0, 0, "R6"); push(27, 1, 5, 1, 0, 0, "R6");
        fire(16'h0800, 0);
        settle("R6"); exp_marks++;
        chk("R6 marks", marks, exp_marks);

        // R6/R7: fail with need-resend set -> waits for scan
        cfg(10, 2, 3);
        push(26, 2, 3, 0, 0, 1, "R6");
        fire(16'h0400, 0);
        settle("R6"); exp_marks++;
        chk("R6 marks", marks, exp_marks);
        push(26, 2, 3, 1, 0, 0, "R7");
        fire('0, 1);
        settle("R7");
        fire('0, 1);
        settle("R7 second scan");

        // R7/R10: scan and fresh arrival in the same cycle
        cfg(7, 8, 1); cfg(9, 9, 2);
        push(23, 8, 1, 0, 0, 1, "R7"); push(25, 9, 2, 0, 0, 1, "R7");
        fire(16'h0280, 0);
        settle("R7"); exp_marks += 2;
        chk("R7 marks", marks, exp_marks);
        push(23, 8, 1, 1, 0, 0, "R7"); push(25, 9, 2, 1, 0, 0, "R7");
        push(16, 4, 2, 1, 0, 0, "R10");
        fire(16'h0001, 1);
        settle("R10");

        // R11: masked while marked
        cfg(8, 6, 0);
        push(24, 6, 0, 0, 0, 1, "R11");
        fire(16'h0100, 0);
        settle("R11"); exp_marks++;
        chk("R11 marks", marks, exp_marks);
        cfg(8, 255, 0);
        fire('0, 1);
        settle("R11 masked scan");
        push(24, 6, 4, 1, 0, 0, "R11");
        cfg(8, 6, 4);
        settle("R11");
        fire('0, 1);
        settle("R11 mark cleared");

        // R8: end-of-interrupt with level high / low
        cfg(4, 12, 1);
        level[4] = 1;
        push(20, 12, 1, 1, 0, 0, "R8");
        @(negedge clk); eoi_v = 1; eoi_irq = 8'd20;
        @(negedge clk); eoi_v = 0;
        settle("R8");
        level[4] = 0;
        @(negedge clk); eoi_v = 1; eoi_irq = 8'd20;
        @(negedge clk); eoi_v = 0;
        settle("R8 level low");

        // R9: redeliver in-bank; IPI code ignored
        push(19, 5, 0, 1, 0, 0, "R9");
        @(negedge clk); redo_v = 1; redo_irq = 8'd19;
        @(negedge clk); redo_v = 1; redo_irq = 8'd2;
        @(negedge clk); redo_v = 0;
        settle("R9");
        chk("R9 final marks", marks, exp_marks);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule